// File: doc/BRIEF.md
# Packet Buffer Address Pointer

This block holds the 16-bit pointer and control word that addresses packet buffer memory during data-port transfers. A register-write port loads the word one byte lane at a time or both together. The block always presents the current byte offset inside the selected packet, together with the packet number that the memory controller should combine with it. After each data-port access, the pointer can advance by the width of that access, so software can stream a packet through the data port without reloading the address.

A single control bit chooses which side of the buffer is addressed. When it is set, the receive area is addressed and the packet number is taken live from the head of the receive queue. When it is clear, the transmit area is addressed and the packet number comes from a separately loaded 7-bit register. A read-only status bit shows whether the data path still holds pending data, and a direction bit is passed through for the data path to use.

Top module: `buf_ptr_unit`

## Requirements
- R1: After reset, every stored bit is 0: the pointer, the control bits and the packet number register. With `data_pending` low, `reg_rd_data` then reads 0x0000, and `buf_addr`, `buf_pkt`, `buf_rx_area` and `buf_read` are all 0.
- R2: A write with `reg_wr_en` high loads the low byte lane (strobe `reg_wr_be[0]`) into pointer bits 7:0. The high lane (strobe `reg_wr_be[1]`) loads bit 15 (receive select), bit 14 (auto-advance), bit 13 (read direction) and pointer bits 10:8. A lane whose strobe is low keeps its value. `reg_rd_data` returns the word in the same bit positions.
- R3: When auto-advance is set, each cycle with `acc_valid` high and no register write adds a step to the pointer. The step is chosen by `acc_size`: 1 for 2'b00 (byte), 2 for 2'b01 (word), and 4 for 2'b10 or 2'b11 (double word). `buf_addr` shows the old value during the access and the advanced value from the next cycle.
- R4: When auto-advance is clear, data accesses leave the pointer unchanged.
- R5: The pointer is 11 bits wide and wraps modulo 2048 when it advances.
- R6: A register write that falls in the same cycle as a data access wins. Each written lane takes the written value, each unwritten lane keeps its old value, and no step is added.
- R7: With the receive-select bit set, `buf_rx_area` is 1 and `buf_pkt` follows `rxq_head` in the same cycle.
- R8: With the receive-select bit clear, `buf_rx_area` is 0 and `buf_pkt` equals the value last loaded through `pnum_wr_en`/`pnum_wr_data`. The value is used exactly as written, all 7 bits with no masking, from the cycle after the load.
- R9: Bit 11 of `reg_rd_data` mirrors `data_pending`. Bit 12 always reads 0. Values written to bits 12 and 11 are ignored.
- R10: `buf_read` equals the stored read-direction bit (bit 13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe for the pointer/control word |
| reg_wr_be | input | 2 | Byte-lane enables; bit 0 selects the low lane, bit 1 the high lane |
| reg_wr_data | input | 16 | Write data for the pointer/control word |
| reg_rd_data | output | 16 | Readback of the pointer/control word, including the status bit |
| pnum_wr_en | input | 1 | Load strobe for the packet number register |
| pnum_wr_data | input | 7 | Packet number to load |
| rxq_head | input | 7 | Packet number at the head of the receive queue |
| data_pending | input | 1 | Data path not-empty status, shown at readback bit 11 |
| acc_valid | input | 1 | A data-port access takes place this cycle |
| acc_size | input | 2 | Access width code: 00 byte, 01 word, 1x double word |
| buf_addr | output | 11 | Byte offset inside the selected packet |
| buf_pkt | output | 7 | Packet number for the access |
| buf_rx_area | output | 1 | 1 when the receive area is addressed, 0 for the transmit area |
| buf_read | output | 1 | Read-direction control bit |

## Verification
A register write and an auto-advancing data access can land on the same clock edge. In that case the write must fully replace the step on the lanes it touches, and on the untouched lane the old value must survive with no step added. The bench drives both strobes in one cycle, first with both lanes written and then with only the low lane, using a double-word access so that any leaked increment shows up as an offset of 4. The next cycle's `buf_addr` is compared with the written value combined with the old high lane. The same cycle-level approach checks the packet number select: `rxq_head` and the loaded register are kept different, and the receive-select bit is toggled.

// File: rtl/buf_ptr_pkg.sv
package buf_ptr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_DWALT = 2'b11
  } acc_size_e;

  localparam int unsigned WORD_W  = 16;
  localparam int unsigned BIT_RX   = 15;
  localparam int unsigned BIT_AUTO = 14;
  localparam int unsigned BIT_RD   = 13;
  localparam int unsigned BIT_RSV  = 12;
  localparam int unsigned BIT_NE   = 11;
  localparam int unsigned PTR_FIELD_W = 11;
  localparam int unsigned STEP_W = 3;

  typedef struct packed {
    logic rx_sel;
    logic auto_en;
    logic rd_dir;
  } ptr_ctrl_t;

endpackage

// File: rtl/buf_ptr_rst_sync.sv
module buf_ptr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/buf_ptr_step.sv
module buf_ptr_step
  import buf_ptr_pkg::*;
(
  input  logic [1:0]        acc_size,
  output logic [STEP_W-1:0] step
);
  acc_size_e sz;

  always_comb begin
    sz = acc_size_e'(acc_size);
    unique case (sz)
      SZ_BYTE:  step = STEP_W'(1);
      SZ_WORD:  step = STEP_W'(2);
      SZ_DWORD: step = STEP_W'(4);
      SZ_DWALT: step = STEP_W'(4);
      default:  step = STEP_W'(4);
    endcase
  end
endmodule

// File: rtl/buf_ptr_store.sv
module buf_ptr_store
  import buf_ptr_pkg::*;
#(
  parameter int unsigned PTR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              acc_valid,
  input  logic              auto_en,
  input  logic [STEP_W-1:0] step,
  output logic [PTR_W-1:0]  ptr_q
);
  localparam int unsigned HI_W = PTR_W - 8;

  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic             wr_any;
  logic             unused_hi;

  assign unused_hi = ^wr_data[WORD_W-1:PTR_W];
  assign wr_any    = wr_lo | wr_hi;
  assign ptr_en    = wr_any | (acc_valid & auto_en);

  always_comb begin
    ptr_d = ptr_q;
    if (wr_any) begin
      if (wr_lo) ptr_d[7:0]       = wr_data[7:0];
      if (wr_hi) ptr_d[PTR_W-1:8] = wr_data[8 +: HI_W];
    end else if (acc_valid && auto_en) begin
      ptr_d = ptr_q + PTR_W'(step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R4: no advance while auto-advance is off
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !auto_en && !wr_any) |=> $stable(ptr_q));

  // R3: advance by the decoded access step
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && auto_en && !wr_any) |=> (ptr_q == PTR_W'($past(ptr_q) + $past(step))));

  // R5: all-ones pointer plus one byte returns to zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && auto_en && !wr_any && (ptr_q == {PTR_W{1'b1}}) && (step == STEP_W'(1)))
      |=> (ptr_q == '0));

  // R6: full write beats a simultaneous access
  p_wr_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && wr_hi) |=> (ptr_q == $past(wr_data[PTR_W-1:0])));

endmodule

// File: rtl/buf_ptr_ctrl.sv
module buf_ptr_ctrl
  import buf_ptr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hi,
  input  logic [2:0] wr_bits,
  output ptr_ctrl_t ctrl_q
);
  ptr_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_hi) ctrl_d = ptr_ctrl_t'(wr_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_hi) ctrl_q <= ctrl_d;
  end

  // R2: control bits only change on a high-lane write
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(ctrl_q));

endmodule

// File: rtl/buf_ptr_pkt_sel.sv
module buf_ptr_pkt_sel #(
  parameter int unsigned PKT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pnum_we,
  input  logic [PKT_W-1:0] pnum_wd,
  input  logic             rx_sel,
  input  logic [PKT_W-1:0] rx_head,
  output logic [PKT_W-1:0] pkt_out
);
  logic [PKT_W-1:0] pnum_q;
  logic [PKT_W-1:0] pnum_d;

  always_comb begin
    pnum_d = pnum_q;
    if (pnum_we) pnum_d = pnum_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pnum_q <= '0;
    else if (pnum_we) pnum_q <= pnum_d;
  end

  assign pkt_out = rx_sel ? rx_head : pnum_q;

  // R8: a load is kept unmasked
  p_pnum_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pnum_we |=> (pnum_q == $past(pnum_wd)));

endmodule

// File: rtl/buf_ptr_unit.sv
module buf_ptr_unit
  import buf_ptr_pkg::*;
#(
  parameter int unsigned PTR_W = 11,
  parameter int unsigned PKT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_be,
  input  logic [WORD_W-1:0] reg_wr_data,
  output logic [WORD_W-1:0] reg_rd_data,
  input  logic              pnum_wr_en,
  input  logic [PKT_W-1:0]  pnum_wr_data,
  input  logic [PKT_W-1:0]  rxq_head,
  input  logic              data_pending,
  input  logic              acc_valid,
  input  logic [1:0]        acc_size,
  output logic [PTR_W-1:0]  buf_addr,
  output logic [PKT_W-1:0]  buf_pkt,
  output logic              buf_rx_area,
  output logic              buf_read
);
  logic              rst_n_s;
  logic              wr_lo;
  logic              wr_hi;
  logic [STEP_W-1:0] step;
  logic [PTR_W-1:0]  ptr_q;
  ptr_ctrl_t         ctrl_q;

  assign wr_lo = reg_wr_en & reg_wr_be[0];
  assign wr_hi = reg_wr_en & reg_wr_be[1];

  buf_ptr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  buf_ptr_step u_step (
    .acc_size (acc_size),
    .step     (step)
  );

  buf_ptr_store #(.PTR_W(PTR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_data   (reg_wr_data),
    .acc_valid (acc_valid),
    .auto_en   (ctrl_q.auto_en),
    .step      (step),
    .ptr_q     (ptr_q)
  );

  buf_ptr_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_hi   (wr_hi),
    .wr_bits (reg_wr_data[BIT_RX:BIT_RD]),
    .ctrl_q  (ctrl_q)
  );

  buf_ptr_pkt_sel #(.PKT_W(PKT_W)) u_pkt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pnum_we (pnum_wr_en),
    .pnum_wd (pnum_wr_data),
    .rx_sel  (ctrl_q.rx_sel),
    .rx_head (rxq_head),
    .pkt_out (buf_pkt)
  );

  assign reg_rd_data = {ctrl_q.rx_sel, ctrl_q.auto_en, ctrl_q.rd_dir,
                        1'b0, data_pending, PTR_FIELD_W'(ptr_q)};
  assign buf_addr    = ptr_q;
  assign buf_rx_area = ctrl_q.rx_sel;
  assign buf_read    = ctrl_q.rd_dir;

  // R7: receive side takes the live queue head
  p_src_rx_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    buf_rx_area |-> (buf_pkt == rxq_head));

  // R9: status bit mirrors input, reserved bit reads zero
  p_ne_ro_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_rd_data[BIT_NE] == data_pending) && !reg_rd_data[BIT_RSV]);

endmodule

// File: tb/buf_ptr_unit_tb.sv
module buf_ptr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_be;
  logic [15:0] reg_wr_data;
  logic [15:0] reg_rd_data;
  logic        pnum_wr_en;
  logic [6:0]  pnum_wr_data;
  logic [6:0]  rxq_head;
  logic        data_pending;
  logic        acc_valid;
  logic [1:0]  acc_size;
  logic [10:0] buf_addr;
  logic [6:0]  buf_pkt;
  logic        buf_rx_area;
  logic        buf_read;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  buf_ptr_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_be(reg_wr_be), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data),
    .pnum_wr_en(pnum_wr_en), .pnum_wr_data(pnum_wr_data),
    .rxq_head(rxq_head), .data_pending(data_pending),
    .acc_valid(acc_valid), .acc_size(acc_size),
    .buf_addr(buf_addr), .buf_pkt(buf_pkt),
    .buf_rx_area(buf_rx_area), .buf_read(buf_read)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] be, input logic [15:0] d);
    reg_wr_en = 1'b1; reg_wr_be = be; reg_wr_data = d;
    tick();
    reg_wr_en = 1'b0; reg_wr_be = 2'b00;
  endtask

  task automatic access(input logic [1:0] sz);
    acc_valid = 1'b1; acc_size = sz;
    tick();
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 readback", 32'(reg_rd_data), 32'h0000);
    chk("R1 addr", 32'(buf_addr), 0);
    chk("R1 pkt", 32'(buf_pkt), 0);
    chk("R1 flags", {30'd0, buf_rx_area, buf_read}, 0);
  endtask

  task automatic t_fields();
    wr_reg(2'b11, 16'hE5A3);
    chk("R2 full write", 32'(reg_rd_data), 32'hE5A3);
    chk("R2 addr", 32'(buf_addr), 32'h5A3);
    chk("R10 read dir", 32'(buf_read), 1);
    wr_reg(2'b01, 16'hFF12);
    chk("R2 low lane only", 32'(reg_rd_data), 32'hE512);
    wr_reg(2'b10, 16'h03FF);
    chk("R2 high lane only", 32'(reg_rd_data), 32'h0312);
    chk("R10 read dir cleared", 32'(buf_read), 0);
  endtask

  task automatic t_status();
    data_pending = 1'b1;
    #1 chk("R9 status mirror", 32'(reg_rd_data), 32'h0B12);
    data_pending = 1'b0;
    wr_reg(2'b10, 16'h1F00);
    chk("R9 bits 12/11 ignored", 32'(reg_rd_data), 32'h0712);
    data_pending = 1'b1;
    #1 chk("R9 status after write", 32'(reg_rd_data), 32'h0F12);
    data_pending = 1'b0;
  endtask

  task automatic t_steps();
    wr_reg(2'b11, 16'h4000);
    acc_valid = 1'b1; acc_size = 2'b00;
    #1 chk("R3 addr during access", 32'(buf_addr), 0);
    tick(); acc_valid = 1'b0;
    chk("R3 byte step", 32'(buf_addr), 1);
    access(2'b01);
    chk("R3 word step", 32'(buf_addr), 3);
    access(2'b10);
    chk("R3 dword step", 32'(buf_addr), 7);
    access(2'b11);
    chk("R3 dword alt step", 32'(buf_addr), 11);
    tick();
    chk("R3 idle no step", 32'(buf_addr), 11);
  endtask

  task automatic t_hold();
    wr_reg(2'b11, 16'h0020);
    access(2'b00);
    access(2'b01);
    access(2'b10);
    chk("R4 hold without auto", 32'(buf_addr), 32'h20);
  endtask

  task automatic t_wrap();
    wr_reg(2'b11, 16'h47FF);
    access(2'b00);
    chk("R5 wrap byte", 32'(buf_addr), 0);
    wr_reg(2'b11, 16'h47FE);
    access(2'b10);
    chk("R5 wrap dword", 32'(buf_addr), 2);
  endtask

  task automatic t_prio();
    wr_reg(2'b11, 16'h4300);
    acc_valid = 1'b1; acc_size = 2'b10;
    wr_reg(2'b11, 16'h4100);
    acc_valid = 1'b0;
    chk("R6 full write beats step", 32'(buf_addr), 32'h100);
    acc_valid = 1'b1; acc_size = 2'b10;
    wr_reg(2'b01, 16'h0055);
    acc_valid = 1'b0;
    chk("R6 low write keeps high lane", 32'(buf_addr), 32'h155);
  endtask

  task automatic t_pkt();
    rxq_head = 7'h2A;
    pnum_wr_en = 1'b1; pnum_wr_data = 7'h7F;
    tick(); pnum_wr_en = 1'b0;
    chk("R8 tx pkt unmasked", 32'(buf_pkt), 32'h7F);
    chk("R8 tx area", 32'(buf_rx_area), 0);
    wr_reg(2'b10, 16'h8000);
    chk("R7 rx pkt", 32'(buf_pkt), 32'h2A);
    chk("R7 rx area", 32'(buf_rx_area), 1);
    rxq_head = 7'h11;
    #1 chk("R7 rx head live", 32'(buf_pkt), 32'h11);
    pnum_wr_en = 1'b1; pnum_wr_data = 7'h05;
    tick(); pnum_wr_en = 1'b0;
    chk("R7 rx ignores register", 32'(buf_pkt), 32'h11);
    wr_reg(2'b10, 16'h0000);
    chk("R8 tx pkt reload", 32'(buf_pkt), 32'h05);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_be = 2'b00; reg_wr_data = '0;
    pnum_wr_en = 1'b0; pnum_wr_data = '0; rxq_head = 7'h33;
    data_pending = 1'b0; acc_valid = 1'b0; acc_size = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fields();
    t_status();
    t_steps();
    t_hold();
    t_wrap();
    t_prio();
    t_pkt();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule